// File: doc/BRIEF.md
# Clock Output Stop and Power-Down Control

This block is a small register file, programmed over an SMBus-style two-wire link, that decides how a set of differential CPU clock outputs are driven. Each output can be running, stopped, or high-impedance. In the stopped state the true side is held at its stop level and the complement side is low. The block holds two control bytes. Writable fields set the stop and power-down policy, per-output free-run exemptions, an output enable for pair 2, a spread-enable flag and a frequency select for an auxiliary output. Read-only fields return the levels of the external select, multiplier, CPU-stop and PCI-stop pins.

The two-wire bus is oversampled in the core clock domain. Each transaction is either a byte write (address, command index, data) or a byte read (address and command index, repeated start, address with the read bit, one data byte, NOT-acknowledge). Every external pin goes through a two-flop synchronizer. A new drive state is applied to an output only while that output's synchronized reference clock is low, so a change never clips a clock pulse.

Top module: `clkstop_ctl`

## Requirements
- R1: A byte write to device address DEV_ADDR (default 7'h69), with the R/W bit 0, is acknowledged on the address, index and data bytes. Index 0 or 1 then updates the writable fields of that byte.
- R2: A byte read returns the indexed byte MSB first in the data phase, after the repeated start and the read address. The slave releases SDA for the master's NOT-acknowledge.
- R3: A transaction whose address differs from DEV_ADDR receives no acknowledge, and it does not change any register.
- R4: A command index other than 0 or 1 is acknowledged. A write to such an index changes no register, and a read from it returns 8'h00.
- R5: After reset all writable bits are 0, except byte 0 bit 3 (PCI stop enable) and byte 1 bit 2 (pair 2 enable), which are 1. All outputs are in the running state.
- R6: Byte 0 bit 4 reads the CPU-stop pin and byte 0 bits 2:0 read fsel[2:0]. Byte 1 bit 7 reads the mult0 pin and byte 1 bits 1:0 read 0. Writes to these bits have no effect.
- R7: pci_stop_n_int is the AND of byte 0 bit 3 and the pci_stop_n pin, and byte 0 bit 3 reads back that AND.
- R8: Byte 0 bit 7 drives spread_en and byte 0 bit 5 drives aux_sel_48m (1 selects 48 MHz).
- R9: With pd_n low, every output is stopped (code 2'b01) when both byte 0 bit 6 and byte 1 bit 6 are 0. It is high-impedance (2'b10) when either bit is 1.
- R10: With pd_n high and cpu_stop_n low, outputs 0, 1 and 2 take their free-run bit from byte 1 bits 3, 4 and 5. An output whose bit is 1 keeps running (2'b00). Any other output goes to 2'b01 when byte 1 bit 6 is 0 and to 2'b10 when it is 1. Byte 0 bit 6 has no effect here.
- R11: With byte 1 bit 2 at 0, output 2 is high-impedance (2'b10) whatever the other inputs.
- R12: drive_state[2i+1:2i] never shows 2'b11. It changes only while the synchronized ref_clk[i] is low, and a pin change reaches it three core cycles after the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl | input | 1 | Two-wire bus clock |
| sda_i | input | 1 | Two-wire bus data level |
| sda_pull_low | output | 1 | When 1, the slave pulls SDA low |
| pd_n | input | 1 | Power-down pin, active low |
| cpu_stop_n | input | 1 | CPU clock stop pin, active low |
| pci_stop_n | input | 1 | PCI clock stop pin, active low |
| fsel | input | 3 | Frequency select pins |
| mult0 | input | 1 | Current multiplier pin |
| ref_clk | input | 3 | Reference clock of each output |
| drive_state | output | 6 | Two bits per output: 00 run, 01 stop, 10 high-Z |
| spread_en | output | 1 | Spread-spectrum enable |
| aux_sel_48m | output | 1 | Auxiliary output select, 1 selects 48 MHz |
| pci_stop_n_int | output | 1 | Internal PCI stop, active low |

## Verification
The bench builds the block with its defaults: DEV_ADDR 7'h69, SYNC_STAGES 2 and three outputs. With these values the pin-to-output latency is a fixed three cycles, and every free-run bit and the pair 2 enable map onto a real output. One neighbouring address (7'h6A) checks that only the exact match is acknowledged. Holding the reference clocks high shows that the drive states are frozen, and releasing one reference at a time shows that each output is gated on its own.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;
  localparam int NUM_CPU = 3;
  localparam int OE_IDX  = 2;

  typedef enum logic [1:0] {
    DRV_RUN  = 2'b00,
    DRV_STOP = 2'b01,
    DRV_HIZ  = 2'b10
  } drv_e;

  typedef struct packed {
    logic               spread;
    logic               pd_tri;
    logic               aux48;
    logic               pci_en;
    logic               stop_tri;
    logic [NUM_CPU-1:0] free_run;
    logic               oe2;
  } cfg_t;

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_AACK, S_CMD, S_CACK,
    S_WDAT, S_WACK, S_RDAT, S_RACK, S_WAIT
  } smb_st_e;
endpackage

// File: rtl/clkstop_sync.sv
module clkstop_sync #(
  parameter int           W       = 1,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) stg[k] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/clkstop_smb.sv
module clkstop_smb
  import clkstop_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_s,
  input  logic       sda_s,
  input  logic [7:0] rd_data,
  output logic       wr_en,
  output logic [7:0] idx,
  output logic [7:0] wr_data,
  output logic       sda_low
);
  smb_st_e    st_q, st_n;
  logic [3:0] cnt_q, cnt_n;
  logic [7:0] sh_q, sh_n, idx_n;
  logic       rw_q, rw_n, low_n, scl_q, sda_q;
  logic       start, stop, rise, fall;

  assign start = scl_s & scl_q & sda_q & ~sda_s;
  assign stop  = scl_s & scl_q & ~sda_q & sda_s;
  assign rise  = scl_s & ~scl_q;
  assign fall  = ~scl_s & scl_q;

  always_comb begin
    st_n = st_q; cnt_n = cnt_q; sh_n = sh_q; idx_n = idx;
    rw_n = rw_q; low_n = sda_low; wr_en = 1'b0;
    if (start) begin
      st_n = S_ADDR; cnt_n = '0; low_n = 1'b0;
    end else if (stop) begin
      st_n = S_IDLE; low_n = 1'b0;
    end else begin
      case (st_q)
        S_ADDR, S_CMD, S_WDAT: begin
          if (rise && cnt_q < 4'd8) begin
            sh_n  = {sh_q[6:0], sda_s};
            cnt_n = cnt_q + 4'd1;
          end else if (fall && cnt_q == 4'd8) begin
            cnt_n = '0;
            if (st_q == S_ADDR) begin
              if (sh_q[7:1] == DEV_ADDR) begin
                st_n = S_AACK; rw_n = sh_q[0]; low_n = 1'b1;
              end else begin
                st_n = S_IDLE;
              end
            end else if (st_q == S_CMD) begin
              idx_n = sh_q; st_n = S_CACK; low_n = 1'b1;
            end else begin
              wr_en = 1'b1; st_n = S_WACK; low_n = 1'b1;
            end
          end
        end
        S_AACK: if (fall) begin
          if (rw_q) begin
            st_n = S_RDAT; sh_n = rd_data; low_n = ~rd_data[7]; cnt_n = '0;
          end else begin
            st_n = S_CMD; low_n = 1'b0;
          end
        end
        S_CACK: if (fall) begin st_n = S_WDAT; low_n = 1'b0; end
        S_WACK: if (fall) begin st_n = S_WAIT; low_n = 1'b0; end
        S_RDAT: if (fall) begin
          if (cnt_q == 4'd7) begin
            st_n = S_RACK; low_n = 1'b0;
          end else begin
            cnt_n = cnt_q + 4'd1; sh_n = {sh_q[6:0], 1'b0}; low_n = ~sh_q[6];
          end
        end
        S_RACK: if (rise) st_n = S_WAIT;
        default: ;
      endcase
    end
  end

  assign wr_data = sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; cnt_q <= '0; sh_q <= '0; idx <= '0;
      rw_q <= 1'b0; sda_low <= 1'b0; scl_q <= 1'b1; sda_q <= 1'b1;
    end else begin
      st_q <= st_n; cnt_q <= cnt_n; sh_q <= sh_n; idx <= idx_n;
      rw_q <= rw_n; sda_low <= low_n; scl_q <= scl_s; sda_q <= sda_s;
    end
  end
endmodule

// File: rtl/clkstop_regs.sv
module clkstop_regs
  import clkstop_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] idx,
  input  logic [7:0] wr_data,
  input  logic       cpu_stop_n_s,
  input  logic       pci_int,
  input  logic [2:0] fsel_s,
  input  logic       mult0_s,
  output cfg_t       cfg,
  output logic [7:0] rd_data
);
  cfg_t cfg_n;

  always_comb begin
    cfg_n = cfg;
    if (wr_en && idx == 8'd0) begin
      cfg_n.spread = wr_data[7];
      cfg_n.pd_tri = wr_data[6];
      cfg_n.aux48  = wr_data[5];
      cfg_n.pci_en = wr_data[3];
    end else if (wr_en && idx == 8'd1) begin
      cfg_n.stop_tri = wr_data[6];
      cfg_n.free_run = wr_data[5:3];
      cfg_n.oe2      = wr_data[2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg        <= '0;
      cfg.pci_en <= 1'b1;
      cfg.oe2    <= 1'b1;
    end else begin
      cfg <= cfg_n;
    end
  end

  always_comb begin
    case (idx)
      8'd0:    rd_data = {cfg.spread, cfg.pd_tri, cfg.aux48, cpu_stop_n_s, pci_int, fsel_s};
      8'd1:    rd_data = {mult0_s, cfg.stop_tri, cfg.free_run, cfg.oe2, 2'b00};
      default: rd_data = 8'h00;
    endcase
  end
endmodule

// File: rtl/clkstop_gate.sv
module clkstop_gate
  import clkstop_pkg::*;
#(
  parameter int N_OUT = NUM_CPU
) (
  input  logic               clk,
  input  logic               rst_n,
  input  cfg_t               cfg,
  input  logic               pd_n_s,
  input  logic               cpu_stop_n_s,
  input  logic [N_OUT-1:0]   ref_s,
  output logic [2*N_OUT-1:0] drv
);
  for (genvar i = 0; i < N_OUT; i++) begin : g_out
    drv_e req, cur;

    always_comb begin
      if (i == OE_IDX && !cfg.oe2)
        req = DRV_HIZ;
      else if (!pd_n_s)
        req = (cfg.pd_tri || cfg.stop_tri) ? DRV_HIZ : DRV_STOP;
      else if (!cpu_stop_n_s && !cfg.free_run[i])
        req = cfg.stop_tri ? DRV_HIZ : DRV_STOP;
      else
        req = DRV_RUN;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cur <= DRV_RUN;
      else if (!ref_s[i]) cur <= req;
    end

    assign drv[2*i +: 2] = cur;
  end
endmodule

// File: rtl/clkstop_ctl.sv
module clkstop_ctl
  import clkstop_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 scl,
  input  logic                 sda_i,
  output logic                 sda_pull_low,
  input  logic                 pd_n,
  input  logic                 cpu_stop_n,
  input  logic                 pci_stop_n,
  input  logic [2:0]           fsel,
  input  logic                 mult0,
  input  logic [NUM_CPU-1:0]   ref_clk,
  output logic [2*NUM_CPU-1:0] drive_state,
  output logic                 spread_en,
  output logic                 aux_sel_48m,
  output logic                 pci_stop_n_int
);
  logic               scl_s, sda_s, pd_n_s, cpu_stop_n_s, pci_s, mult0_s, wr_en, pci_int;
  logic [2:0]         fsel_s;
  logic [NUM_CPU-1:0] ref_s;
  logic [7:0]         idx, wr_data, rd_data;
  cfg_t               cfg;

  clkstop_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_bus_sync (
    .clk(clk), .rst_n(rst_n), .d({scl, sda_i}), .q({scl_s, sda_s}));

  clkstop_sync #(.W(7), .STAGES(SYNC_STAGES), .RST_VAL(7'b1110000)) u_pin_sync (
    .clk(clk), .rst_n(rst_n),
    .d({pd_n, cpu_stop_n, pci_stop_n, mult0, fsel}),
    .q({pd_n_s, cpu_stop_n_s, pci_s, mult0_s, fsel_s}));

  clkstop_sync #(.W(NUM_CPU), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_ref_sync (
    .clk(clk), .rst_n(rst_n), .d(ref_clk), .q(ref_s));

  clkstop_smb #(.DEV_ADDR(DEV_ADDR)) u_smb (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s), .rd_data(rd_data),
    .wr_en(wr_en), .idx(idx), .wr_data(wr_data), .sda_low(sda_pull_low));

  assign pci_int = cfg.pci_en & pci_s;

  clkstop_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .idx(idx), .wr_data(wr_data),
    .cpu_stop_n_s(cpu_stop_n_s), .pci_int(pci_int), .fsel_s(fsel_s),
    .mult0_s(mult0_s), .cfg(cfg), .rd_data(rd_data));

  clkstop_gate #(.N_OUT(NUM_CPU)) u_gate (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .pd_n_s(pd_n_s),
    .cpu_stop_n_s(cpu_stop_n_s), .ref_s(ref_s), .drv(drive_state));

  assign spread_en      = cfg.spread;
  assign aux_sel_48m    = cfg.aux48;
  assign pci_stop_n_int = pci_int;
endmodule

// File: rtl/clkstop_ctl_chk.sv
module clkstop_ctl_chk
  import clkstop_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_CPU-1:0]   ref_s,
  input logic                 pd_n_s,
  input logic                 cpu_stop_n_s,
  input cfg_t                 cfg,
  input logic [2*NUM_CPU-1:0] drive_state
);
  for (genvar i = 0; i < NUM_CPU; i++) begin : g_chk
    a_r12_hold_ref_high: assert property (@(posedge clk) disable iff (!rst_n)
      ref_s[i] |=> $stable(drive_state[2*i +: 2]));
    a_r12_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
      drive_state[2*i +: 2] != 2'b11);
  end

  a_r11_pair2_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg.oe2 && !ref_s[OE_IDX]) |=> drive_state[2*OE_IDX +: 2] == 2'b10);

  a_r9_pd_tristate: assert property (@(posedge clk) disable iff (!rst_n)
    (!pd_n_s && (cfg.pd_tri || cfg.stop_tri) && !ref_s[0]) |=> drive_state[1:0] == 2'b10);

  a_r10_free_run_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_n_s && !cpu_stop_n_s && cfg.free_run[0] && !ref_s[0]) |=> drive_state[1:0] == 2'b00);
endmodule

bind clkstop_ctl clkstop_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ref_s(ref_s), .pd_n_s(pd_n_s),
  .cpu_stop_n_s(cpu_stop_n_s), .cfg(cfg), .drive_state(drive_state));

// File: tb/clkstop_ctl_bench.sv
module clkstop_ctl_bench;
  localparam int         Q   = 8;
  localparam logic [6:0] DEV = 7'h69;

  logic       clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1;
  logic       pd_n = 1'b1, cpu_stop_n = 1'b1, pci_stop_n = 1'b1, mult0 = 1'b1;
  logic [2:0] fsel = 3'b101, ref_clk = 3'b000;
  logic [5:0] drive_state;
  logic       sda_pull_low, spread_en, aux_sel_48m, pci_stop_n_int, sda_bus;
  int         vectors = 0, miscompares = 0;

  assign sda_bus = sda_m & ~sda_pull_low;
  always #10 clk = ~clk;

  clkstop_ctl u_clkstop_ctl (
    .clk(clk), .rst_n(rst_n), .scl(scl), .sda_i(sda_bus), .sda_pull_low(sda_pull_low),
    .pd_n(pd_n), .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n), .fsel(fsel),
    .mult0(mult0), .ref_clk(ref_clk), .drive_state(drive_state), .spread_en(spread_en),
    .aux_sel_48m(aux_sel_48m), .pci_stop_n_int(pci_stop_n_int));

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl = 1'b1; tick(Q); sda_m = 1'b0; tick(Q); scl = 1'b0;
  endtask
  task automatic bus_rstart();
    scl = 1'b0; tick(Q); sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q); scl = 1'b0;
  endtask
  task automatic bus_stop();
    scl = 1'b0; tick(Q); sda_m = 1'b0; tick(Q); scl = 1'b1; tick(Q);
    sda_m = 1'b1; tick(2*Q);
  endtask
  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      scl = 1'b0; tick(Q); sda_m = b[i]; tick(Q); scl = 1'b1; tick(2*Q);
    end
    scl = 1'b0; tick(Q); sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q);
    ack = ~sda_bus; tick(Q); scl = 1'b0;
  endtask
  task automatic recv_byte(output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      scl = 1'b0; tick(2*Q); scl = 1'b1; tick(Q); b[i] = sda_bus; tick(Q);
    end
    scl = 1'b0; tick(2*Q); scl = 1'b1; tick(2*Q); scl = 1'b0;
  endtask

  task automatic reg_write(input logic [6:0] a, input logic [7:0] ix,
                           input logic [7:0] d, output logic ok);
    logic k0, k1, k2;
    bus_start(); send_byte({a, 1'b0}, k0); send_byte(ix, k1); send_byte(d, k2); bus_stop();
    ok = k0 & k1 & k2;
  endtask
  task automatic reg_read(input logic [7:0] ix, output logic [7:0] d, output logic ok);
    logic k0, k1, k2;
    bus_start(); send_byte({DEV, 1'b0}, k0); send_byte(ix, k1);
    bus_rstart(); send_byte({DEV, 1'b1}, k2); recv_byte(d); bus_stop();
    ok = k0 & k1 & k2;
  endtask

  task automatic t_reset();
    logic [7:0] d; logic ok;
    check("R5 drive", {2'b00, drive_state}, 8'h00);
    check("R5 outs", {5'b0, spread_en, aux_sel_48m, pci_stop_n_int}, 8'h01);
    reg_read(8'd0, d, ok); check("R2 ack", {7'b0, ok}, 8'h01);
    check("R5 R6 byte0", d, 8'h1D);
    reg_read(8'd1, d, ok); check("R5 R6 byte1", d, 8'h84);
  endtask

  task automatic t_write_byte0();
    logic [7:0] d; logic ok;
    reg_write(DEV, 8'd0, 8'hE0, ok); check("R1 ack", {7'b0, ok}, 8'h01);
    check("R8 spread/aux", {6'b0, spread_en, aux_sel_48m}, 8'h03);
    check("R7 pci off", {7'b0, pci_stop_n_int}, 8'h00);
    reg_read(8'd0, d, ok); check("R2 R7 readback", d, 8'hF5);
  endtask

  task automatic t_pci_and();
    logic [7:0] d; logic ok;
    reg_write(DEV, 8'd0, 8'h08, ok);
    check("R7 and 1&1", {7'b0, pci_stop_n_int}, 8'h01);
    pci_stop_n = 1'b0; tick(6);
    check("R7 and 1&0", {7'b0, pci_stop_n_int}, 8'h00);
    reg_read(8'd0, d, ok); check("R7 read and", d, 8'h15);
    pci_stop_n = 1'b1; tick(6);
  endtask

  task automatic t_readonly();
    logic [7:0] d; logic ok;
    reg_write(DEV, 8'd0, 8'h1F, ok);
    reg_read(8'd0, d, ok); check("R6 ro write", d, 8'h1D);
    reg_write(DEV, 8'd1, 8'h87, ok);
    reg_read(8'd1, d, ok); check("R6 byte1 ro", d, 8'h84);
    fsel = 3'b010; cpu_stop_n = 1'b0; mult0 = 1'b0; tick(6);
    reg_read(8'd0, d, ok); check("R6 pins b0", d, 8'h0A);
    reg_read(8'd1, d, ok); check("R6 pins b1", d, 8'h04);
    fsel = 3'b101; cpu_stop_n = 1'b1; mult0 = 1'b1; tick(6);
  endtask

  task automatic t_bad_index();
    logic [7:0] d; logic ok;
    reg_write(DEV, 8'd5, 8'hFF, ok); check("R4 ack", {7'b0, ok}, 8'h01);
    reg_read(8'd0, d, ok); check("R4 b0 kept", d, 8'h1D);
    reg_read(8'd1, d, ok); check("R4 b1 kept", d, 8'h84);
    reg_read(8'd5, d, ok); check("R4 read zero", d, 8'h00);
  endtask

  task automatic t_bad_addr();
    logic [7:0] d; logic ok, k0, k1, k2;
    bus_start(); send_byte({7'h6A, 1'b0}, k0); send_byte(8'd0, k1);
    send_byte(8'hE0, k2); bus_stop();
    check("R3 no ack", {5'b0, k0, k1, k2}, 8'h00);
    check("R3 outs", {6'b0, spread_en, aux_sel_48m}, 8'h00);
    reg_read(8'd0, d, ok); check("R3 unchanged", d, 8'h1D);
  endtask

  task automatic t_pd();
    logic ok;
    pd_n = 1'b0; tick(6); check("R9 pd stop", {2'b0, drive_state}, 8'h15);
    reg_write(DEV, 8'd0, 8'h48, ok); tick(2); check("R9 pd hiz", {2'b0, drive_state}, 8'h2A);
    reg_write(DEV, 8'd0, 8'h08, ok); reg_write(DEV, 8'd1, 8'h44, ok); tick(2);
    check("R9 stop_tri override", {2'b0, drive_state}, 8'h2A);
    reg_write(DEV, 8'd1, 8'h04, ok); pd_n = 1'b1; tick(6);
    check("R9 release", {2'b0, drive_state}, 8'h00);
  endtask

  task automatic t_cpustop();
    logic ok;
    reg_write(DEV, 8'd1, 8'h14, ok); cpu_stop_n = 1'b0; tick(6);
    check("R10 free run out1", {2'b0, drive_state}, 8'h11);
    reg_write(DEV, 8'd0, 8'h48, ok); tick(2);
    check("R10 pd_tri no effect", {2'b0, drive_state}, 8'h11);
    reg_write(DEV, 8'd0, 8'h08, ok); reg_write(DEV, 8'd1, 8'h54, ok); tick(2);
    check("R10 stop hiz", {2'b0, drive_state}, 8'h22);
    reg_write(DEV, 8'd1, 8'h04, ok); cpu_stop_n = 1'b1; tick(6);
    check("R10 release", {2'b0, drive_state}, 8'h00);
  endtask

  task automatic t_oe2();
    logic ok;
    reg_write(DEV, 8'd1, 8'h00, ok); tick(2);
    check("R11 pair2 off", {2'b0, drive_state}, 8'h20);
    pd_n = 1'b0; tick(6); check("R11 with pd", {2'b0, drive_state}, 8'h25);
    pd_n = 1'b1; reg_write(DEV, 8'd1, 8'h04, ok); tick(2);
    check("R11 restore", {2'b0, drive_state}, 8'h00);
  endtask

  task automatic t_ref();
    ref_clk = 3'b111; tick(4); pd_n = 1'b0; tick(10);
    check("R12 frozen", {2'b0, drive_state}, 8'h00);
    ref_clk = 3'b110; tick(2); check("R12 not yet", {2'b0, drive_state}, 8'h00);
    tick(4); check("R12 out0 only", {2'b0, drive_state}, 8'h01);
    ref_clk = 3'b000; tick(6); check("R12 all", {2'b0, drive_state}, 8'h15);
    pd_n = 1'b1; tick(2); check("R12 latency", {2'b0, drive_state}, 8'h15);
    tick(1); check("R12 third cycle", {2'b0, drive_state}, 8'h00);
  endtask

  initial begin
    tick(3); rst_n = 1'b1; tick(4);
    t_reset(); t_write_byte0(); t_pci_and(); t_readonly(); t_bad_index();
    t_bad_addr(); t_pd(); t_cpustop(); t_oe2(); t_ref();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule